// File: doc/BRIEF.md
# Start-up Supply Charge Sequencer

This block sequences the high-voltage charging switch that feeds a controller's own supply rail. It reads two sampled voltage codes, one for the supply rail and one for the regulated driver rail, plus three status inputs: burst-mode idle, protection active and start-up complete. From these it drives a current-limited pre-charge enable, a full charge-switch enable, a permit that lets the power stage begin switching, and a one-cycle restart request.

After reset the rail is charged only through the current-limited path, so a shorted rail dissipates little. Once the rail rises above the reset level the full switch takes over and regulates the rail around the start level with a hysteresis band. When the regulated rail is high enough and the start level has been reached, switching is permitted. Once start-up completes the charger turns off and the rail is fed externally. During burst pauses the charger tops the rail up around a lower level, so that the supply undervoltage check does not fire. Under protection the rail is held at the start level again. All voltage codes use 10 mV per LSB on 12 bits.

Top module: `supply_charge_seq`

## Requirements
- R1: After reset, and while the rail code is at or below the reset level (default 350), the block is in pre-charge: chg_lim_en=1, chg_full_en=0, switch_ok=0. The protection input does not take it out of pre-charge.
- R2: A rail code above the reset level in pre-charge moves the block to start regulation on the next edge with chg_lim_en=0 and chg_full_en=1.
- R3: In start regulation and protection, chg_full_en goes to 0 when the rail code exceeds the start level (default 1910) and back to 1 when it falls below start minus hysteresis (default 1840). Between those limits it holds its value.
- R4: When start_done=1 and switch_ok=1 in start regulation, the block enters run. In run both charge enables are 0, whatever the rail code.
- R5: protect=1 in start regulation, run or burst enters protection: switch_ok=0, and the start-level hysteresis of R3 applies. On entry from run or burst the switch is closed. When protect clears, start regulation resumes, and the start level must be exceeded again before switch_ok returns.
- R6: In run, burst_idle=1 enters burst with the switch open. In burst, chg_full_en goes to 1 when the rail code is below the low level (default 1200) and to 0 above low plus hysteresis (default 1250), holding between. burst_idle=0 returns to run.
- R7: switch_ok=1 only when the regulated code is at or above its undervoltage threshold (default 1000). In start regulation it also requires that the start level was exceeded since that state was entered.
- R8: A regulated code below its threshold in run or burst raises restart_req for exactly one cycle and returns the block to pre-charge.
- R9: A rail code below the rail undervoltage level (default 900) in run or burst returns the block to pre-charge without a restart request. A code equal to that level keeps the block running.
- R10: When events coincide, the priority is protection first, then regulated undervoltage (restart), then rail undervoltage, then the burst change.
- R11: rst_n is synchronous and active low. Asserting it in any state returns the block to pre-charge on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_code | input | 12 | Sampled supply-rail voltage, 10 mV/LSB |
| reg_code | input | 12 | Sampled regulated-rail voltage, 10 mV/LSB |
| burst_idle | input | 1 | Burst mode is in its non-switching pause |
| protect | input | 1 | A protection condition is active |
| start_done | input | 1 | Power stage has started switching |
| chg_lim_en | output | 1 | Enable of the current-limited pre-charge path |
| chg_full_en | output | 1 | Enable of the full charge switch |
| switch_ok | output | 1 | Power stage may switch |
| restart_req | output | 1 | One-cycle system restart request |

## Verification
Two pairs of functions can fall in the same cycle. Protection can arrive together with a regulated-rail undervoltage. Regulated-rail and supply-rail undervoltage can also arrive together. The bench drives a run state and then applies both events in the same vector. In the first case it checks that the block enters protection with the switch closed and no restart pulse. In the second it checks that a single restart pulse appears alongside the pre-charge outputs.

// File: rtl/scs_pkg.sv
// Shared types of the supply charge sequencer.
// Assumes: all voltage codes share one width, set by the top.
package scs_pkg;

    typedef enum logic [2:0] {
        ST_PRECHG    = 3'd0,
        ST_REG_START = 3'd1,
        ST_RUN       = 3'd2,
        ST_BURST     = 3'd3,
        ST_PROT      = 3'd4
    } scs_state_e;

    typedef struct packed {
        logic above_rst;
        logic above_start;
        logic below_start_band;
        logic below_low;
        logic above_low_band;
        logic rail_uv;
        logic reg_ok;
    } scs_flags_t;

endpackage

// File: rtl/scs_levels.sv
// Threshold comparators of the supply charge sequencer.
// Compares the two sampled codes against parameter levels and returns flags.
// Assumes: codes are unsigned, 10 mV/LSB, with START_HYST < START_CODE.
module scs_levels #(
    parameter int CODE_W       = 12,
    parameter int RST_CODE     = 350,
    parameter int START_CODE   = 1910,
    parameter int START_HYST   = 70,
    parameter int LOW_CODE     = 1200,
    parameter int LOW_HYST     = 50,
    parameter int RAIL_UV_CODE = 900,
    parameter int REG_UV_CODE  = 1000
) (
    input  logic [CODE_W-1:0] rail_code,
    input  logic [CODE_W-1:0] reg_code,
    output scs_pkg::scs_flags_t flags
);
    localparam logic [CODE_W-1:0] K_RST     = CODE_W'(RST_CODE);
    localparam logic [CODE_W-1:0] K_START   = CODE_W'(START_CODE);
    localparam logic [CODE_W-1:0] K_CLOSE   = CODE_W'(START_CODE - START_HYST);
    localparam logic [CODE_W-1:0] K_LOW     = CODE_W'(LOW_CODE);
    localparam logic [CODE_W-1:0] K_LOW_OPEN = CODE_W'(LOW_CODE + LOW_HYST);
    localparam logic [CODE_W-1:0] K_RAIL_UV = CODE_W'(RAIL_UV_CODE);
    localparam logic [CODE_W-1:0] K_REG_UV  = CODE_W'(REG_UV_CODE);

    // Compare both codes against every level in one flat layer.
    always_comb begin
        flags.above_rst        = rail_code >  K_RST;
        flags.above_start      = rail_code >  K_START;
        flags.below_start_band = rail_code <  K_CLOSE;
        flags.below_low        = rail_code <  K_LOW;
        flags.above_low_band   = rail_code >  K_LOW_OPEN;
        flags.rail_uv          = rail_code <  K_RAIL_UV;
        flags.reg_ok           = reg_code  >= K_REG_UV;
    end

endmodule

// File: rtl/scs_fsm.sv
// State machine of the supply charge sequencer.
// Holds the operating state, the hysteretic switch bit, the start-reached
// flag and the restart pulse. Outputs decode from registers and reg_ok.
// Assumes: flags come from scs_levels in the same cycle; reset synchronous.
module scs_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  scs_pkg::scs_flags_t flags,
    input  logic               burst_idle,
    input  logic               protect,
    input  logic               start_done,
    output logic               chg_lim_en,
    output logic               chg_full_en,
    output logic               switch_ok,
    output logic               restart_req
);
    import scs_pkg::*;

    scs_state_e state_q, state_d;
    logic       sw_on_q, sw_on_d;
    logic       reached_q, reached_d;
    logic       restart_q, restart_d;
    logic       sw_start, sw_low;

    // Next switch value under each hysteresis rule.
    always_comb begin
        sw_start = flags.above_start ? 1'b0 : (flags.below_start_band ? 1'b1 : sw_on_q);
        sw_low   = flags.below_low   ? 1'b1 : (flags.above_low_band   ? 1'b0 : sw_on_q);
    end

    // Next-state logic with protection > restart > rail UV > burst priority.
    always_comb begin
        state_d   = state_q;
        sw_on_d   = sw_on_q;
        reached_d = reached_q;
        restart_d = 1'b0;
        case (state_q)
            ST_PRECHG: begin
                if (flags.above_rst) begin
                    state_d   = ST_REG_START;
                    sw_on_d   = 1'b1;
                    reached_d = 1'b0;
                end
            end
            ST_REG_START: begin
                sw_on_d = sw_start;
                if (flags.above_start) reached_d = 1'b1;
                if (protect) begin
                    state_d = ST_PROT;
                end else if (start_done && switch_ok) begin
                    state_d = ST_RUN;
                    sw_on_d = 1'b0;
                end
            end
            ST_RUN, ST_BURST: begin
                if (state_q == ST_BURST) sw_on_d = sw_low;
                if (protect) begin
                    state_d = ST_PROT;
                    sw_on_d = 1'b1;
                end else if (!flags.reg_ok) begin
                    state_d   = ST_PRECHG;
                    sw_on_d   = 1'b0;
                    restart_d = 1'b1;
                end else if (flags.rail_uv) begin
                    state_d = ST_PRECHG;
                    sw_on_d = 1'b0;
                end else if (state_q == ST_RUN && burst_idle) begin
                    state_d = ST_BURST;
                    sw_on_d = 1'b0;
                end else if (state_q == ST_BURST && !burst_idle) begin
                    state_d = ST_RUN;
                    sw_on_d = 1'b0;
                end
            end
            ST_PROT: begin
                sw_on_d = sw_start;
                if (!protect) begin
                    state_d   = ST_REG_START;
                    reached_d = 1'b0;
                end
            end
            default: begin
                state_d = ST_PRECHG;
                sw_on_d = 1'b0;
            end
        endcase
    end

    // State registers with synchronous active-low reset into pre-charge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_PRECHG;
            sw_on_q   <= 1'b0;
            reached_q <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            sw_on_q   <= sw_on_d;
            reached_q <= reached_d;
            restart_q <= restart_d;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        chg_lim_en  = (state_q == ST_PRECHG);
        chg_full_en = sw_on_q && (state_q == ST_REG_START || state_q == ST_BURST
                                  || state_q == ST_PROT);
        switch_ok   = flags.reg_ok && ((state_q == ST_REG_START && reached_q)
                                       || state_q == ST_RUN || state_q == ST_BURST);
        restart_req = restart_q;
    end

    AST_PRECHG_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_lim_en && flags.above_rst) |=> (chg_full_en && !chg_lim_en)); // R2
    AST_START_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_REG_START || state_q == ST_PROT) && flags.above_start)
        |=> !chg_full_en); // R3
    AST_LOW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && burst_idle && !protect && flags.reg_ok
         && !flags.rail_uv && flags.below_low) |=> chg_full_en); // R6
    AST_PERMIT_REG: assert property (@(posedge clk) disable iff (!rst_n)
        switch_ok |-> flags.reg_ok); // R7
    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req); // R8
    AST_RESTART_PRECHG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_req) |-> chg_lim_en); // R8
    AST_RAIL_UV: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && flags.rail_uv && flags.reg_ok && !protect)
        |=> (chg_lim_en && !restart_req)); // R9
    AST_PROT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && protect) |=> (!restart_req && !switch_ok)); // R10

endmodule

// File: rtl/supply_charge_seq.sv
// Top of the supply charge sequencer.
// Joins the threshold comparators to the state machine.
// Assumes: codes are sampled in the clk domain upstream.
module supply_charge_seq #(
    parameter int CODE_W       = 12,
    parameter int RST_CODE     = 350,
    parameter int START_CODE   = 1910,
    parameter int START_HYST   = 70,
    parameter int LOW_CODE     = 1200,
    parameter int LOW_HYST     = 50,
    parameter int RAIL_UV_CODE = 900,
    parameter int REG_UV_CODE  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rail_code,
    input  logic [CODE_W-1:0] reg_code,
    input  logic              burst_idle,
    input  logic              protect,
    input  logic              start_done,
    output logic              chg_lim_en,
    output logic              chg_full_en,
    output logic              switch_ok,
    output logic              restart_req
);
    scs_pkg::scs_flags_t flags;

    scs_levels #(
        .CODE_W(CODE_W), .RST_CODE(RST_CODE), .START_CODE(START_CODE),
        .START_HYST(START_HYST), .LOW_CODE(LOW_CODE), .LOW_HYST(LOW_HYST),
        .RAIL_UV_CODE(RAIL_UV_CODE), .REG_UV_CODE(REG_UV_CODE)
    ) u_levels (
        .rail_code(rail_code),
        .reg_code (reg_code),
        .flags    (flags)
    );

    scs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags      (flags),
        .burst_idle (burst_idle),
        .protect    (protect),
        .start_done (start_done),
        .chg_lim_en (chg_lim_en),
        .chg_full_en(chg_full_en),
        .switch_ok  (switch_ok),
        .restart_req(restart_req)
    );

endmodule

// File: tb/sim_supply_charge_seq.sv
// Bench: vector table walked by one loop, then directed reset/corner tests.
module sim_supply_charge_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] rail_code = '0;
    logic [11:0] reg_code = '0;
    logic        burst_idle = 1'b0, protect = 1'b0, start_done = 1'b0;
    logic        chg_lim_en, chg_full_en, switch_ok, restart_req;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_charge_seq u0 (
        .clk(clk), .rst_n(rst_n), .rail_code(rail_code), .reg_code(reg_code),
        .burst_idle(burst_idle), .protect(protect), .start_done(start_done),
        .chg_lim_en(chg_lim_en), .chg_full_en(chg_full_en),
        .switch_ok(switch_ok), .restart_req(restart_req)
    );

    // fields: req(4) rail(12) reg(12) burst prot done | lim full ok rst
    localparam logic [34:0] VEC [NV] = '{
        {4'd1, 12'd0,    12'd0,    3'b000, 4'b1000}, // R1
        {4'd1, 12'd350,  12'd0,    3'b000, 4'b1000}, // R1 boundary
        {4'd2, 12'd351,  12'd0,    3'b000, 4'b0100}, // R2
        {4'd3, 12'd1910, 12'd1200, 3'b000, 4'b0100}, // R3 at start, no open
        {4'd3, 12'd1911, 12'd1200, 3'b000, 4'b0010}, // R3 open, permit
        {4'd3, 12'd1840, 12'd1200, 3'b000, 4'b0010}, // R3 hold
        {4'd3, 12'd1839, 12'd1200, 3'b000, 4'b0110}, // R3 close
        {4'd7, 12'd1850, 12'd999,  3'b000, 4'b0100}, // R7 reg low
        {4'd4, 12'd1850, 12'd1200, 3'b001, 4'b0010}, // R4 enter run
        {4'd4, 12'd1500, 12'd1200, 3'b001, 4'b0010}, // R4 charger off
        {4'd6, 12'd1300, 12'd1200, 3'b101, 4'b0010}, // R6 enter burst
        {4'd6, 12'd1200, 12'd1200, 3'b101, 4'b0010}, // R6 at low, hold
        {4'd6, 12'd1199, 12'd1200, 3'b101, 4'b0110}, // R6 close
        {4'd6, 12'd1250, 12'd1200, 3'b101, 4'b0110}, // R6 hold
        {4'd6, 12'd1251, 12'd1200, 3'b101, 4'b0010}, // R6 open
        {4'd6, 12'd1251, 12'd1200, 3'b001, 4'b0010}, // R6 back to run
        {4'd5, 12'd1251, 12'd1200, 3'b011, 4'b0100}, // R5 enter protection
        {4'd5, 12'd1911, 12'd1200, 3'b011, 4'b0000}, // R5 start hysteresis
        {4'd5, 12'd1911, 12'd1200, 3'b001, 4'b0000}, // R5 release, not reached
        {4'd5, 12'd1911, 12'd1200, 3'b000, 4'b0010}, // R5 reached again
        {4'd4, 12'd1911, 12'd1200, 3'b001, 4'b0010}, // R4 run
        {4'd8, 12'd1911, 12'd999,  3'b001, 4'b1001}, // R8 restart pulse
        {4'd8, 12'd1911, 12'd1200, 3'b000, 4'b0100}, // R8 pulse ends
        {4'd3, 12'd1911, 12'd1200, 3'b000, 4'b0010}, // R3
        {4'd4, 12'd1911, 12'd1200, 3'b001, 4'b0010}, // R4
        {4'd9, 12'd899,  12'd1200, 3'b001, 4'b1000}, // R9 rail uv
        {4'd2, 12'd1911, 12'd1200, 3'b001, 4'b0100}, // R2
        {4'd7, 12'd1911, 12'd1200, 3'b001, 4'b0010}, // R7 reached needed first
        {4'd4, 12'd1911, 12'd1200, 3'b001, 4'b0010}, // R4
        {4'd9, 12'd900,  12'd1200, 3'b001, 4'b0010}, // R9 boundary keeps run
        {4'd10,12'd899,  12'd999,  3'b011, 4'b0100}, // R10 protection wins
        {4'd5, 12'd1911, 12'd1200, 3'b001, 4'b0000}, // R5 release
        {4'd5, 12'd1911, 12'd1200, 3'b001, 4'b0010}, // R5 reached
        {4'd4, 12'd1911, 12'd1200, 3'b001, 4'b0010}, // R4
        {4'd10,12'd899,  12'd999,  3'b001, 4'b1001}  // R10 restart over rail uv
    };

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {chg_lim_en, chg_full_en, switch_ok, restart_req};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: lim/full/ok/rst actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state (R1, R11).
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 reset", 4'b1000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rail_code  = VEC[i][30:19];
            reg_code   = VEC[i][18:7];
            burst_idle = VEC[i][6];
            protect    = VEC[i][5];
            start_done = VEC[i][4];
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec %0d", VEC[i][34:31], i), VEC[i][3:0]);
        end

        // R1: protection while the rail sits below the reset level.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1;
        rail_code = 12'd200; reg_code = 12'd1200;
        protect = 1'b1; burst_idle = 1'b0; start_done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 protect in precharge", 4'b1000);

        // R11: reset in the middle of start regulation.
        @(negedge clk);
        protect = 1'b0; rail_code = 12'd1500;
        @(posedge clk); #1;
        check("R2 charge after precharge", 4'b0100);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R11 reset mid-run", 4'b1000);

        // R8 from burst: regulated rail collapse during a pause.
        @(negedge clk);
        rst_n = 1'b1; rail_code = 12'd1911;
        repeat (2) @(posedge clk);
        @(negedge clk);
        start_done = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        burst_idle = 1'b1; rail_code = 12'd1300;
        @(posedge clk); #1;
        check("R6 burst entry", 4'b0010);
        @(negedge clk);
        reg_code = 12'd500;
        @(posedge clk); #1;
        check("R8 restart from burst", 4'b1001);

        finish_run();
    end

endmodule